// File: doc/BRIEF.md
# Chip-Selected Register File

This block is a small storage array of sixteen 4-bit words. An active-low select and an active-low write strobe control it. Writes are taken on the rising edge of the system clock. Reads are combinational from the addressed word. The output bus is driven to all zeros whenever the array is not selected or is being written. Because of that, several copies can share a wired-OR or simple OR-reduced output when an external address decoder drives their selects, which lets them form deeper arrays.

Two write styles are accepted, and both use the same rule: any clock edge that samples select and write strobe both low stores the data word. In the level style, select stays low and the write strobe is pulsed. In the strobe style, the write strobe, address and data are set up first and then select is pulsed. When the write strobe returns high with select still low, the addressed word appears at the output with no further command.

Top module: `sel_regfile`

## Requirements
- R1: The array holds 16 independent 4-bit words indexed by a 4-bit address. A write changes only the addressed word.
- R2: While `cs_n` is high, no word is written, whatever `we_n`, `addr` and `din` are doing, and `dout` is 4'h0.
- R3: A rising clock edge that samples `cs_n` low and `we_n` low stores `din` into the word at `addr`.
- R4: While `cs_n` and `we_n` are both low, `dout` is 4'h0.
- R5: While `cs_n` is low and `we_n` is high, `dout` shows the word at `addr` in the same cycle, following address changes combinationally.
- R6: When a read of an address directly follows a write to it, the newly written value appears in the first read cycle.
- R7: In the strobe style, `we_n`, `addr` and `din` are held while `cs_n` toggles. Each cycle with `cs_n` low stores the word. Cycles with `cs_n` high store nothing, even if `din` changes during them.
- R8: A rising edge that samples `rst_n` low clears all 16 words to zero. Reset takes priority over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; writes and reset act on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset, clears every word |
| cs_n | input | 1 | Active-low array select |
| we_n | input | 1 | Active-low write strobe |
| addr | input | 4 | Word address |
| din | input | 4 | Write data |
| dout | output | 4 | Read data; zero when deselected or writing |

## Verification
The output gating of R2 and R4 and the read of R5 are due in the same cycle the inputs are applied. A stored word (R3, R6, R7, R8) can be seen only from the cycle after the edge that commits it. The bench drives each cycle's inputs at the falling edge. At that moment it computes the expected output from a reference array that still holds the pre-edge contents, and only then applies the write to that array. The monitor samples 5 ns before the next rising edge, so every comparison covers exactly one combinational result, and each stored value is observed through a later read cycle.

// File: rtl/sel_regfile_pkg.sv
// Package: shared sizes, the access mode type and the mode decode.
// Assumes both control inputs are active low.
package sel_regfile_pkg;

    localparam int SRF_ADDR_W = 4;
    localparam int SRF_DATA_W = 4;

    typedef enum logic [1:0] {
        SRF_IDLE  = 2'd0,
        SRF_WRITE = 2'd1,
        SRF_READ  = 2'd2
    } srf_mode_e;

    // Classifies the current cycle from the two active-low controls.
    function automatic srf_mode_e srf_mode(input logic sel_n, input logic wr_n);
        if (sel_n)     return SRF_IDLE;
        else if (!wr_n) return SRF_WRITE;
        else           return SRF_READ;
    endfunction

endpackage

// File: rtl/srf_decoder.sv
// Address decoder: turns a write request and an address into one-hot
// per-word write selects. Assumes DEPTH == 2**ADDR_W.
module srf_decoder #(
    parameter int ADDR_W = 4,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              wr_go,
    input  logic [ADDR_W-1:0] addr,
    output logic [DEPTH-1:0]  wr_sel
);

    // One select line per word, raised only for the addressed word.
    for (genvar g = 0; g < DEPTH; g++) begin : g_sel
        assign wr_sel[g] = wr_go && (addr == ADDR_W'(g));
    end

endmodule

// File: rtl/srf_array.sv
// Storage array: DEPTH words of DATA_W bits, each written on the rising
// clock edge when its select is high. A synchronous active-low reset
// clears every word and wins over a write. Contents are exposed flat.
module srf_array #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 4,
    localparam int FLAT_W = DEPTH * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DEPTH-1:0]  wr_sel,
    input  logic [DATA_W-1:0] din,
    output logic [FLAT_W-1:0] words_flat
);

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        logic [DATA_W-1:0] word_q;

        // Holds one word: clear on reset, load when selected.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (wr_sel[g]) begin
                word_q <= din;
            end
        end

        assign words_flat[g*DATA_W +: DATA_W] = word_q;
    end

endmodule

// File: rtl/srf_readout.sv
// Read path: selects the addressed word from the flat store and gates
// it to zero unless the cycle is a read. Purely combinational.
module srf_readout
    import sel_regfile_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 4,
    localparam int DEPTH  = 1 << ADDR_W,
    localparam int FLAT_W = DEPTH * DATA_W
) (
    input  logic [FLAT_W-1:0] words_flat,
    input  logic [ADDR_W-1:0] addr,
    input  srf_mode_e         mode,
    output logic [DATA_W-1:0] dout
);

    logic [DATA_W-1:0] picked;

    // Multiplexes the addressed word out of the flat store.
    always_comb begin
        picked = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (addr == ADDR_W'(i)) begin
                picked = words_flat[i*DATA_W +: DATA_W];
            end
        end
    end

    // Forces the bus low outside read cycles.
    always_comb begin
        dout = (mode == SRF_READ) ? picked : '0;
    end

endmodule

// File: rtl/sel_regfile.sv
// Top: 16 x 4 chip-selected register file. Writes on the clock edge when
// cs_n and we_n are both low (level or strobe style), reads
// combinationally otherwise, and drives zero when idle or writing.
module sel_regfile
    import sel_regfile_pkg::*;
#(
    parameter int ADDR_W = SRF_ADDR_W,
    parameter int DATA_W = SRF_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    localparam int DEPTH  = 1 << ADDR_W;
    localparam int FLAT_W = DEPTH * DATA_W;

    srf_mode_e          mode;
    logic [DEPTH-1:0]   wr_sel;
    logic [FLAT_W-1:0]  words_flat;

    // Decodes the access mode of the current cycle.
    always_comb begin
        mode = srf_mode(cs_n, we_n);
    end

    srf_decoder #(.ADDR_W(ADDR_W)) u_dec (
        .wr_go  (mode == SRF_WRITE),
        .addr   (addr),
        .wr_sel (wr_sel)
    );

    srf_array #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_sel     (wr_sel),
        .din        (din),
        .words_flat (words_flat)
    );

    srf_readout #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
        .words_flat (words_flat),
        .addr       (addr),
        .mode       (mode),
        .dout       (dout)
    );

endmodule

// File: rtl/sel_regfile_chk.sv
// Checker: temporal properties of the register file, bound to the top.
// Observes ports plus the flat storage vector.
module sel_regfile_chk #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 4,
    localparam int DEPTH  = 1 << ADDR_W,
    localparam int FLAT_W = DEPTH * DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] din,
    input logic [DATA_W-1:0] dout,
    input logic [FLAT_W-1:0] words_flat
);

    // R2: deselected bus is low.
    p_desel_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> dout == '0);

    // R4: bus is low during a write.
    p_write_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !we_n) |-> dout == '0);

    // R6: read of the just-written address shows the new word.
    p_fresh_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !we_n) |=> (cs_n || !we_n || addr != $past(addr) || dout == $past(din)));

    // R5: consecutive reads of the same address give the same word.
    p_read_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && we_n && $past(!cs_n && we_n) && $stable(addr)) |-> $stable(dout));

    // R8: a reset edge leaves every word zero.
    p_reset_clear_r8: assert property (@(posedge clk)
        !rst_n |=> words_flat == '0);

    // R1, R2, R7: a word not addressed by a write keeps its value.
    for (genvar g = 0; g < DEPTH; g++) begin : g_hold
        p_word_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
            !(!cs_n && !we_n && addr == ADDR_W'(g))
            |=> $stable(words_flat[g*DATA_W +: DATA_W]));
    end

endmodule

bind sel_regfile sel_regfile_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .we_n       (we_n),
    .addr       (addr),
    .din        (din),
    .dout       (dout),
    .words_flat (words_flat)
);

// File: tb/sel_regfile_bench.sv
// Scoreboard bench: the driver applies one cycle at the falling edge,
// pushes the expected bus value from a reference array, then updates
// that array; the monitor compares 5 ns before the next rising edge.
module sel_regfile_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       we_n = 1'b1;
    logic [3:0] addr = 4'h0;
    logic [3:0] din = 4'h0;
    logic [3:0] dout;

    typedef struct {
        logic [3:0] exp;
        string      tag;
    } sb_item_t;

    sb_item_t   sbq[$];
    logic [3:0] ref_mem [16];
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    sel_regfile u_sel_regfile (
        .clk   (clk),
        .rst_n (rst_n),
        .cs_n  (cs_n),
        .we_n  (we_n),
        .addr  (addr),
        .din   (din),
        .dout  (dout)
    );

    // Driver: one cycle of stimulus plus its expected result.
    task automatic cyc(input logic r, input logic c, input logic w,
                       input logic [3:0] a, input logic [3:0] d, input string tag);
        sb_item_t it;
        @(negedge clk);
        rst_n = r; cs_n = c; we_n = w; addr = a; din = d;
        it.exp = (c || !w) ? 4'h0 : ref_mem[a];
        it.tag = tag;
        sbq.push_back(it);
        if (!r) begin
            for (int i = 0; i < 16; i++) ref_mem[i] = 4'h0;
        end else if (!c && !w) begin
            ref_mem[a] = d;
        end
    endtask

    // Monitor: pops and compares one item per cycle.
    initial begin
        sb_item_t it;
        forever begin
            @(negedge clk);
            #5;
            if (sbq.size() > 0) begin
                it = sbq.pop_front();
                n_chk++;
                if (dout !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: dout=%h expected %h", it.tag, dout, it.exp);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: dout=%h expected run end", dout);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) ref_mem[i] = 4'h0;
        // R8/R2: reset cycles, deselected, then a write attempt under reset.
        cyc(0, 1, 1, 4'h0, 4'h0, "R8 reset idle");
        cyc(0, 1, 0, 4'h3, 4'hF, "R2 reset deselected");
        cyc(0, 0, 0, 4'h5, 4'hA, "R8 reset beats write");
        // R8: every word reads zero after reset.
        for (int i = 0; i < 16; i++) cyc(1, 0, 1, 4'(i), 4'h0, "R8 cleared read");
        // R3/R4: back-to-back writes to every address.
        for (int i = 0; i < 16; i++) cyc(1, 0, 0, 4'(i), 4'(i) ^ 4'h9, "R3 R4 level write");
        // R5/R1: read every word back, descending order.
        for (int i = 15; i >= 0; i--) cyc(1, 0, 1, 4'(i), 4'h0, "R5 R1 read back");
        // R6: write then immediately read the same address.
        cyc(1, 0, 0, 4'h7, 4'h2, "R4 write");
        cyc(1, 0, 1, 4'h7, 4'h0, "R6 read after write");
        cyc(1, 0, 0, 4'hE, 4'h0, "R4 write zero");
        cyc(1, 0, 1, 4'hE, 4'h0, "R6 zero read after write");
        cyc(1, 0, 1, 4'h6, 4'h0, "R1 neighbour intact");
        // R2: deselected with write strobe low and changing data.
        cyc(1, 1, 0, 4'h1, 4'hF, "R2 desel write");
        cyc(1, 1, 0, 4'h2, 4'h0, "R2 desel write");
        cyc(1, 1, 1, 4'h1, 4'h5, "R2 desel read");
        cyc(1, 0, 1, 4'h1, 4'h0, "R2 word 1 unchanged");
        cyc(1, 0, 1, 4'h2, 4'h0, "R2 word 2 unchanged");
        // R7: strobe writes, we_n held low while cs_n toggles.
        cyc(1, 1, 0, 4'h9, 4'hC, "R7 setup");
        cyc(1, 0, 0, 4'h9, 4'hC, "R7 strobe low");
        cyc(1, 1, 0, 4'h9, 4'hC, "R7 strobe high");
        cyc(1, 1, 0, 4'h9, 4'h3, "R7 data moves while high");
        cyc(1, 0, 1, 4'h9, 4'h0, "R7 strobe stored");
        cyc(1, 1, 0, 4'hB, 4'h6, "R7 setup");
        cyc(1, 0, 0, 4'hB, 4'h6, "R7 strobe low");
        cyc(1, 1, 0, 4'hB, 4'h6, "R7 hold");
        cyc(1, 0, 0, 4'hC, 4'h1, "R7 strobe low");
        cyc(1, 1, 0, 4'hC, 4'h1, "R7 hold");
        cyc(1, 0, 1, 4'hB, 4'h0, "R7 word B");
        cyc(1, 0, 1, 4'hC, 4'h0, "R7 word C");
        cyc(1, 0, 1, 4'hA, 4'h0, "R1 word A untouched");
        // R8: mid-run reset then all words zero.
        cyc(0, 1, 1, 4'h0, 4'h0, "R8 reset");
        for (int i = 0; i < 16; i++) cyc(1, 0, 1, 4'(i), 4'h0, "R8 cleared again");
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule